// File: doc/BRIEF.md
# Dual-Direction UART Rate Strobe Generator

This block turns one system clock into the timing enables that a UART transmitter and receiver need. A shared coarse prescaler, selectable among the division factors 1, 3, 4 and 13, produces a tick. The transmit side and the receive side each divide that tick by their own power of two. Each side can then apply its own optional fine divider of 1 to 255. The result, per direction, is a single-cycle 16x oversampling strobe and a single-cycle once-per-bit strobe. With a 8 MHz clock, a prescaler of 13 and both power-of-two dividers at 1, both directions run at the nominal 38400 baud.

Each direction is held idle while its enable is low. When enable rises, every counter of that direction starts from zero, so the first strobe comes a full period later. The settings a direction uses are captured while it is disabled. The shared prescaler setting is captured while both directions are disabled. Changes made during operation therefore take effect only at the next enable.

Top module: `uart_rate_gen`

## Requirements
- R1: The 2-bit prescaler select encodes 00 as 1, 01 as 3, 10 as 4 and 11 as 13 system clocks per prescaler tick, shared by both directions.
- R2: A direction's 3-bit divider select value n divides the prescaler tick rate by 2^n (n = 0..7).
- R3: A nonzero 8-bit fine divider value E makes the oversample strobe period PR x 2^n x E system clocks for that direction.
- R4: A fine divider value of zero leaves the oversample strobe period at PR x 2^n system clocks.
- R5: The bit strobe is high only together with an oversample strobe, on every 16th oversample strobe, so its period is 16 times the oversample period.
- R6: With period N, counting the first cycle in which enable is high as cycle 0, the first oversample strobe appears in cycle N-1 and the first bit strobe in cycle 16N-1.
- R7: While a direction's enable is low, that direction produces no strobes.
- R8: Changes to a direction's divider select or fine divider value, and prescaler select changes while either direction is enabled, have no effect until the direction is disabled and enabled again.
- R9: The transmit and receive directions use their own divider settings and enables independently of each other.
- R10: Prescaler select 11, divider select 0 and fine value 0 give an oversample period of 13 clocks and a bit period of 208 clocks (38400 baud nominal at 8 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_sel | input | 2 | Shared prescaler select |
| tx_div_sel | input | 3 | Transmit power-of-two divider select |
| rx_div_sel | input | 3 | Receive power-of-two divider select |
| tx_epr | input | 8 | Transmit fine divider, 0 disables it |
| rx_epr | input | 8 | Receive fine divider, 0 disables it |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_os_stb | output | 1 | Transmit 16x oversample strobe |
| tx_bit_stb | output | 1 | Transmit bit strobe |
| rx_os_stb | output | 1 | Receive 16x oversample strobe |
| rx_bit_stb | output | 1 | Receive bit strobe |

## Verification
The rate path is measured with every prescaler code at a fixed divider, which separates a wrong decode from a wrong divider. Divider selects at both ends of their range and fine values of 0, 5 and 255 are also tried, and they tell a missing bypass apart from an off-by-one count. The time from enable to the first strobe and the spacing between strobes are both measured, so a counter that is not cleared on enable shows up as a different first delay. Running both directions at once with different settings shows that they do not interfere. Changing the settings during a run and then re-enabling shows that the change is ignored at first and taken up afterwards.

// File: rtl/uart_rate_pkg.sv
`timescale 1ns/1ps
package uart_rate_pkg;
   localparam int PR_SEL_W = 2;
   localparam int PR_MAX   = 13;

   // coarse prescaler factors, indexed by the select code
   function automatic int pr_factor(input logic [PR_SEL_W-1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 3;
         2'b10:   return 4;
         default: return PR_MAX;
      endcase
   endfunction
endpackage

// File: rtl/urg_prescale.sv
`timescale 1ns/1ps
module urg_prescale
   import uart_rate_pkg::*;
#(
   parameter int SEL_W = PR_SEL_W,
   localparam int CNT_W = $clog2(PR_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_m1;

   initial begin
      assert (SEL_W == PR_SEL_W) else $error("prescaler select width must match the factor table");
   end

   assign lim_m1 = CNT_W'(pr_factor(sel_q) - 1);
   assign tick   = run && (cnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt   <= '0;
      end else if (!run) begin
         sel_q <= sel;
         cnt   <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_PR_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= lim_m1)) else $error("prescaler count out of range"); // R1
   AST_PR_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(sel_q)) else $error("prescaler select moved while running"); // R8
endmodule

// File: rtl/urg_pow2_div.sv
`timescale 1ns/1ps
module urg_pow2_div #(
   parameter int SEL_W = 3,
   localparam int CNT_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick_in,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_out
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 4) else $error("divider select width out of supported range");
   end

   assign mask     = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << sel) - 1'b1);
   assign tick_out = tick_in && (cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!en)       cnt <= '0;
      else if (tick_out)  cnt <= '0;
      else if (tick_in)   cnt <= cnt + 1'b1;
   end

   AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= mask)) else $error("power-of-two count out of range"); // R2
   AST_DIV_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0)) else $error("divider not cleared while idle"); // R7
endmodule

// File: rtl/urg_ext_div.sv
`timescale 1ns/1ps
module urg_ext_div #(
   parameter int EPR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick_in,
   input  logic [EPR_W-1:0] epr,
   output logic             tick_out
);
   logic [EPR_W-1:0] cnt;
   logic             active;

   initial begin
      assert (EPR_W >= 1 && EPR_W <= 16) else $error("fine divider width out of supported range");
   end

   assign active   = (epr != '0);
   assign tick_out = active ? (tick_in && (cnt == epr - 1'b1)) : tick_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!en)       cnt <= '0;
      else if (tick_out)  cnt <= '0;
      else if (tick_in)   cnt <= cnt + 1'b1;
   end

   AST_EXT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && active) |-> (cnt < epr)) else $error("fine count out of range"); // R3
   AST_EXT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (cnt == '0)) else $error("fine counter moved while bypassed"); // R4
endmodule

// File: rtl/urg_channel.sv
`timescale 1ns/1ps
module urg_channel #(
   parameter int DIV_SEL_W = 3,
   parameter int EPR_W     = 8,
   parameter int OS_FACTOR = 16,
   localparam int BC_W     = $clog2(OS_FACTOR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 pr_tick,
   input  logic [DIV_SEL_W-1:0] div_sel,
   input  logic [EPR_W-1:0]     epr,
   output logic                 os_stb,
   output logic                 bit_stb
);
   logic [DIV_SEL_W-1:0] div_sel_q;
   logic [EPR_W-1:0]     epr_q;
   logic                 div_tick;
   logic [BC_W-1:0]      bcnt;

   initial begin
      assert (OS_FACTOR >= 2 && (OS_FACTOR & (OS_FACTOR - 1)) == 0)
         else $error("oversample factor must be a power of two");
   end

   // settings are captured only while this direction is idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sel_q <= '0;
         epr_q     <= '0;
      end else if (!en) begin
         div_sel_q <= div_sel;
         epr_q     <= epr;
      end
   end

   urg_pow2_div #(.SEL_W(DIV_SEL_W)) i_pow2 (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_in(pr_tick && en),
      .sel(div_sel_q), .tick_out(div_tick)
   );

   urg_ext_div #(.EPR_W(EPR_W)) i_ext (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_in(div_tick),
      .epr(epr_q), .tick_out(os_stb)
   );

   assign bit_stb = os_stb && (bcnt == BC_W'(OS_FACTOR - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bcnt <= '0;
      else if (!en)     bcnt <= '0;
      else if (os_stb)  bcnt <= bcnt + 1'b1;
   end

   AST_BIT_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> (bcnt == '0)) else $error("bit counter did not wrap"); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!os_stb && !bit_stb)) else $error("strobe while disabled"); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> ($stable(div_sel_q) && $stable(epr_q))) else $error("settings moved while enabled"); // R8
endmodule

// File: rtl/uart_rate_gen.sv
`timescale 1ns/1ps
module uart_rate_gen
   import uart_rate_pkg::*;
#(
   parameter int DIV_SEL_W = 3,
   parameter int EPR_W     = 8,
   parameter int OS_FACTOR = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PR_SEL_W-1:0]  pr_sel,
   input  logic [DIV_SEL_W-1:0] tx_div_sel,
   input  logic [DIV_SEL_W-1:0] rx_div_sel,
   input  logic [EPR_W-1:0]     tx_epr,
   input  logic [EPR_W-1:0]     rx_epr,
   input  logic                 tx_en,
   input  logic                 rx_en,
   output logic                 tx_os_stb,
   output logic                 tx_bit_stb,
   output logic                 rx_os_stb,
   output logic                 rx_bit_stb
);
   localparam int N_DIR = 2;   // index 0 transmit, 1 receive

   logic                 pr_tick;
   logic [N_DIR-1:0]     en_v, os_v, bit_v;
   logic [DIV_SEL_W-1:0] sel_v [N_DIR];
   logic [EPR_W-1:0]     epr_v [N_DIR];

   assign en_v     = {rx_en, tx_en};
   assign sel_v[0] = tx_div_sel;
   assign sel_v[1] = rx_div_sel;
   assign epr_v[0] = tx_epr;
   assign epr_v[1] = rx_epr;

   urg_prescale #(.SEL_W(PR_SEL_W)) i_pre (
      .clk(clk), .rst_n(rst_n), .run(|en_v), .sel(pr_sel), .tick(pr_tick)
   );

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      urg_channel #(.DIV_SEL_W(DIV_SEL_W), .EPR_W(EPR_W), .OS_FACTOR(OS_FACTOR)) i_chan (
         .clk(clk), .rst_n(rst_n), .en(en_v[d]), .pr_tick(pr_tick),
         .div_sel(sel_v[d]), .epr(epr_v[d]), .os_stb(os_v[d]), .bit_stb(bit_v[d])
      );
   end

   assign tx_os_stb  = os_v[0];
   assign tx_bit_stb = bit_v[0];
   assign rx_os_stb  = os_v[1];
   assign rx_bit_stb = bit_v[1];
endmodule

// File: tb/test_uart_rate_gen.sv
`timescale 1ns/1ps
module test_uart_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pr_sel = '0;
   logic [2:0] tx_div_sel = '0, rx_div_sel = '0;
   logic [7:0] tx_epr = '0, rx_epr = '0;
   logic       tx_en = 1'b0, rx_en = 1'b0;
   logic       tx_os_stb, tx_bit_stb, rx_os_stb, rx_bit_stb;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_rate_gen i_uart_rate_gen (
      .clk(clk), .rst_n(rst_n), .pr_sel(pr_sel),
      .tx_div_sel(tx_div_sel), .rx_div_sel(rx_div_sel),
      .tx_epr(tx_epr), .rx_epr(rx_epr), .tx_en(tx_en), .rx_en(rx_en),
      .tx_os_stb(tx_os_stb), .tx_bit_stb(tx_bit_stb),
      .rx_os_stb(rx_os_stb), .rx_bit_stb(rx_bit_stb)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic stop_all();
      @(negedge clk); tx_en = 1'b0; rx_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic start(input bit t, input bit r);
      @(negedge clk); tx_en = t; rx_en = r; #1;
   endtask

   // sample one direction from cycle 0 on: first strobe, spacing, first bit strobe
   task automatic meas(input bit rx, input int lim, output int f_os, output int p_os,
                       output int f_bit, output int bad);
      int seen = 0;
      f_os = -1; p_os = -1; f_bit = -1; bad = 0;
      for (int k = 0; k < lim; k++) begin
         logic os, bt;
         os = rx ? rx_os_stb : tx_os_stb;
         bt = rx ? rx_bit_stb : tx_bit_stb;
         if (bt && !os) bad++;
         if (bt && f_bit < 0) f_bit = k;
         if (os) begin
            if (seen == 0) f_os = k;
            else if (seen == 1) p_os = k - f_os;
            seen++;
         end
         if (seen >= 2 && f_bit >= 0) break;
         @(negedge clk); #1;
      end
   endtask

   task automatic rate_case(input string req, input bit rx, input logic [1:0] ps,
                            input logic [2:0] ds, input logic [7:0] e, input int n);
      int f_os, p_os, f_bit, bad;
      stop_all();
      pr_sel = ps;
      if (rx) begin rx_div_sel = ds; rx_epr = e; end
      else    begin tx_div_sel = ds; tx_epr = e; end
      start(!rx, rx);
      meas(rx, 16 * n + 8, f_os, p_os, f_bit, bad);
      check(req, "first oversample strobe cycle", f_os, n - 1);
      check(req, "oversample period", p_os, n);
      check("R5/R6", "first bit strobe cycle", f_bit, 16 * n - 1);
      check("R5", "bit strobe without oversample strobe", bad, 0);
   endtask

   task automatic t_reset();
      int hits = 0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk); #1;
         hits += int'(tx_os_stb) + int'(tx_bit_stb) + int'(rx_os_stb) + int'(rx_bit_stb);
      end
      check("R7", "strobes after reset with both disabled", hits, 0);
   endtask

   task automatic t_prescaler();
      rate_case("R1", 1'b0, 2'b00, 3'd1, 8'd0, 2);
      rate_case("R1", 1'b0, 2'b01, 3'd1, 8'd0, 6);
      rate_case("R1", 1'b1, 2'b10, 3'd1, 8'd0, 8);
      rate_case("R1", 1'b1, 2'b11, 3'd1, 8'd0, 26);
   endtask

   task automatic t_pow2();
      rate_case("R2", 1'b0, 2'b00, 3'd7, 8'd0, 128);
      rate_case("R2", 1'b1, 2'b00, 3'd3, 8'd0, 8);
      rate_case("R2", 1'b1, 2'b00, 3'd0, 8'd0, 1);
   endtask

   task automatic t_fine();
      rate_case("R3", 1'b0, 2'b01, 3'd2, 8'd5, 60);
      rate_case("R3", 1'b1, 2'b00, 3'd0, 8'd255, 255);
      rate_case("R3", 1'b0, 2'b00, 3'd0, 8'd1, 1);
      rate_case("R4", 1'b1, 2'b01, 3'd2, 8'd0, 12);
   endtask

   task automatic t_baud38400();
      rate_case("R10", 1'b0, 2'b11, 3'd0, 8'd0, 13);
      rate_case("R10", 1'b1, 2'b11, 3'd0, 8'd0, 13);
   endtask

   task automatic t_disabled();
      int hits = 0;
      stop_all();
      pr_sel = 2'b00; tx_div_sel = 3'd0; tx_epr = 8'd0;
      rx_div_sel = 3'd0; rx_epr = 8'd0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk); #1;
         hits += int'(tx_os_stb) + int'(tx_bit_stb) + int'(rx_os_stb) + int'(rx_bit_stb);
      end
      check("R7", "strobes while disabled at fastest setting", hits, 0);
      start(1'b1, 1'b0);
      hits = 0;
      for (int k = 0; k < 100; k++) begin
         hits += int'(rx_os_stb) + int'(rx_bit_stb);
         @(negedge clk); #1;
      end
      check("R7", "receive strobes while only transmit enabled", hits, 0);
   endtask

   task automatic t_independent();
      int ft = -1, fr = -1, ct = 0, cr = 0;
      stop_all();
      pr_sel = 2'b01; tx_div_sel = 3'd0; tx_epr = 8'd0;
      rx_div_sel = 3'd2; rx_epr = 8'd3;
      start(1'b1, 1'b1);
      for (int k = 0; k < 360; k++) begin
         if (tx_os_stb) begin if (ft < 0) ft = k; ct++; end
         if (rx_os_stb) begin if (fr < 0) fr = k; cr++; end
         @(negedge clk); #1;
      end
      check("R9", "transmit first strobe with both enabled", ft, 2);
      check("R9", "receive first strobe with both enabled", fr, 35);
      check("R9", "transmit strobes in 360 cycles", ct, 120);
      check("R9", "receive strobes in 360 cycles", cr, 10);
   endtask

   task automatic t_cfg_frozen();
      int f_os, p_os, f_bit, bad;
      stop_all();
      pr_sel = 2'b00; tx_div_sel = 3'd2; tx_epr = 8'd0;
      start(1'b1, 1'b0);
      repeat (6) @(negedge clk);
      pr_sel = 2'b11; tx_div_sel = 3'd1; tx_epr = 8'd3;
      #1;
      meas(1'b0, 200, f_os, p_os, f_bit, bad);
      check("R8", "period after change while enabled", p_os, 4);
      stop_all();
      start(1'b1, 1'b0);
      meas(1'b0, 16 * 78 + 8, f_os, p_os, f_bit, bad);
      check("R8", "first strobe after re-enable", f_os, 77);
      check("R8", "period after re-enable", p_os, 78);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_prescaler();
      t_pow2();
      t_fine();
      t_baud38400();
      t_disabled();
      t_independent();
      t_cfg_frozen();
      stop_all();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule